// File: doc/BRIEF.md
# FIFO Threshold Interrupt Aggregator

This block raises the interrupt lines of a multichannel sample-rate converter. Every channel owns an input FIFO, which is refilled by a producer, and an output FIFO, which is drained by a consumer. The block receives the current fill level of each FIFO and single-cycle overflow and underflow pulses for each channel. It compares each level with a programmable per-FIFO threshold and evaluates group conditions that need every FIFO of a programmable membership set to meet its threshold together. The results drive five shared lines that an interrupt controller or a DMA engine can use as triggers.

Each interrupt class keeps its per-source enables in a register that software changes only through a separate write-one-to-set address and a separate write-one-to-clear address. Because of this, two agents that each own different sources never need a read-modify-write. FIFO and group lines are level-sensitive and follow the levels with one register stage. Error events are captured in per-channel sticky flags, which stay set until software acknowledges them. The register port is a plain write strobe with address and data. Reads are combinational from the same address.

Top module: `fifo_irq_agg`

## Requirements
- R1: `irq_infifo` is high in the cycle after a clock edge at which some channel c had input-enable bit c set and `in_level[c*6 +: 6]` strictly less than its input threshold. Otherwise it is low.
- R2: `irq_outfifo` is high in the cycle after a clock edge at which some channel c had output-enable bit c set and `out_level[c*6 +: 6]` strictly greater than its output threshold. A level equal to the threshold does not assert it.
- R3: `irq_ingrp` is high after an edge at which some group g had input-group enable bit g set and every input FIFO selected by that group's mask (bit c selects channel c) was below its threshold. `irq_outgrp` behaves the same way for output groups, where each selected output FIFO must be above its threshold.
- R4: A group whose membership mask is all zero never contributes to `irq_ingrp` or `irq_outgrp`.
- R5: When `reg_valid` is high at an edge, writing a set address ORs the low data bits into that class's enables. Writing a clear address removes the set data bits from the enables. Zero data bits leave the enables unchanged. The status address returns the enables on `reg_rdata`, zero-extended. The set and clear addresses read as 0. The class addresses are: input FIFO 0x00/0x01/0x02, output FIFO 0x03/0x04/0x05, input group 0x06/0x07/0x08, output group 0x09/0x0A/0x0B, error 0x0C/0x0D/0x0E (status/set/clear).
- R6: The input threshold of channel c is at 0x10+c and the output threshold of channel c is at 0x18+c, each stored in the low 6 data bits. The input-group mask of group g is at 0x20+g and the output-group mask of group g is at 0x24+g. All of these read back what was written.
- R7: An overflow or underflow pulse on channel c sets sticky flag c at that edge, whatever the error enables hold. Reading 0x0F returns the flags. `irq_error` is high after an edge when a flag that is set or being set at that edge has its error-enable bit set.
- R8: Writing 0x0F clears the flags whose data bits are 1. Zero bits leave flags alone. An event on a channel in the same cycle as its acknowledge leaves the flag set.
- R9: After reset, all enables, thresholds, masks and flags are 0 and all five interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_level | input | 48 | Input FIFO fill levels, channel c at bits c*6 +: 6 |
| out_level | input | 48 | Output FIFO fill levels, channel c at bits c*6 +: 6 |
| ovf_pulse | input | 8 | Per-channel overflow event |
| unf_pulse | input | 8 | Per-channel underflow event |
| reg_valid | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_infifo | output | 1 | Any enabled input FIFO below threshold |
| irq_outfifo | output | 1 | Any enabled output FIFO above threshold |
| irq_ingrp | output | 1 | Any enabled input group fully below threshold |
| irq_outgrp | output | 1 | Any enabled output group fully above threshold |
| irq_error | output | 1 | Any enabled sticky error flag |

## Verification
Directed level sweeps put a single enabled channel at one less than its threshold, at the threshold and at one more. These cases separate a strict comparison from an inclusive one, and they separate an enabled source from a masked one. Group checks drive a member set where all but one member qualifies, and a set with an empty mask while all levels qualify. These cases separate an AND over the members from an OR, and they show whether the empty-mask guard is present. A long run of random levels, thresholds, masks, enable writes and error pulses is compared against bench functions. Directed error cases separate capture from enable masking, partial acknowledges from full ones, and the case where an event arrives in the same cycle as its acknowledge.

// File: rtl/fia_pkg.sv
`timescale 1ns/1ps
package fia_pkg;
  localparam int ADDR_W = 6;

  // enable classes: status / set / clear addresses
  localparam logic [ADDR_W-1:0] A_IN_STS  = 6'h00;
  localparam logic [ADDR_W-1:0] A_IN_SET  = 6'h01;
  localparam logic [ADDR_W-1:0] A_IN_CLR  = 6'h02;
  localparam logic [ADDR_W-1:0] A_OUT_STS = 6'h03;
  localparam logic [ADDR_W-1:0] A_OUT_SET = 6'h04;
  localparam logic [ADDR_W-1:0] A_OUT_CLR = 6'h05;
  localparam logic [ADDR_W-1:0] A_IG_STS  = 6'h06;
  localparam logic [ADDR_W-1:0] A_IG_SET  = 6'h07;
  localparam logic [ADDR_W-1:0] A_IG_CLR  = 6'h08;
  localparam logic [ADDR_W-1:0] A_OG_STS  = 6'h09;
  localparam logic [ADDR_W-1:0] A_OG_SET  = 6'h0A;
  localparam logic [ADDR_W-1:0] A_OG_CLR  = 6'h0B;
  localparam logic [ADDR_W-1:0] A_ER_STS  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_ER_SET  = 6'h0D;
  localparam logic [ADDR_W-1:0] A_ER_CLR  = 6'h0E;
  localparam logic [ADDR_W-1:0] A_ER_ACK  = 6'h0F;
  localparam logic [ADDR_W-1:0] A_TBL     = 6'h10;
endpackage

// File: rtl/fia_regs.sv
`timescale 1ns/1ps
module fia_regs
  import fia_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int LVL_W   = 6,
  parameter int NUM_GRP = 4,
  parameter int REG_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_vld,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [REG_W-1:0]                     wr_data,
  input  logic [NUM_CH-1:0]                    err_flags,
  output logic [REG_W-1:0]                     rd_data,
  output logic [NUM_CH-1:0]                    en_in,
  output logic [NUM_CH-1:0]                    en_out,
  output logic [NUM_GRP-1:0]                   en_ig,
  output logic [NUM_GRP-1:0]                   en_og,
  output logic [NUM_CH-1:0]                    en_err,
  output logic [NUM_CH-1:0]                    err_ack,
  output logic [NUM_CH-1:0][LVL_W-1:0]         thr_in,
  output logic [NUM_CH-1:0][LVL_W-1:0]         thr_out,
  output logic [NUM_GRP-1:0][NUM_CH-1:0]       mask_in,
  output logic [NUM_GRP-1:0][NUM_CH-1:0]       mask_out
);
  localparam logic [ADDR_W-1:0] TIN_BASE  = A_TBL;
  localparam logic [ADDR_W-1:0] TOUT_BASE = A_TBL + ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] GIN_BASE  = A_TBL + ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] GOUT_BASE = A_TBL + ADDR_W'(2 * NUM_CH + NUM_GRP);

  logic [NUM_CH-1:0]               en_in_d, en_out_d, en_err_d;
  logic [NUM_GRP-1:0]              en_ig_d, en_og_d;
  logic [NUM_CH-1:0][LVL_W-1:0]    thr_in_d, thr_out_d;
  logic [NUM_GRP-1:0][NUM_CH-1:0]  mask_in_d, mask_out_d;
  logic [NUM_CH-1:0]               dch;
  logic [NUM_GRP-1:0]              dgr;

  assign dch = wr_data[NUM_CH-1:0];
  assign dgr = wr_data[NUM_GRP-1:0];

  // next state
  always_comb begin
    en_in_d    = en_in;
    en_out_d   = en_out;
    en_ig_d    = en_ig;
    en_og_d    = en_og;
    en_err_d   = en_err;
    thr_in_d   = thr_in;
    thr_out_d  = thr_out;
    mask_in_d  = mask_in;
    mask_out_d = mask_out;
    err_ack    = '0;
    if (wr_vld) begin
      case (addr)
        A_IN_SET:  en_in_d  = en_in  | dch;
        A_IN_CLR:  en_in_d  = en_in  & ~dch;
        A_OUT_SET: en_out_d = en_out | dch;
        A_OUT_CLR: en_out_d = en_out & ~dch;
        A_IG_SET:  en_ig_d  = en_ig  | dgr;
        A_IG_CLR:  en_ig_d  = en_ig  & ~dgr;
        A_OG_SET:  en_og_d  = en_og  | dgr;
        A_OG_CLR:  en_og_d  = en_og  & ~dgr;
        A_ER_SET:  en_err_d = en_err | dch;
        A_ER_CLR:  en_err_d = en_err & ~dch;
        A_ER_ACK:  err_ack  = dch;
        default: ;
      endcase
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == TIN_BASE + ADDR_W'(c))  thr_in_d[c]  = wr_data[LVL_W-1:0];
        if (addr == TOUT_BASE + ADDR_W'(c)) thr_out_d[c] = wr_data[LVL_W-1:0];
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (addr == GIN_BASE + ADDR_W'(g))  mask_in_d[g]  = dch;
        if (addr == GOUT_BASE + ADDR_W'(g)) mask_out_d[g] = dch;
      end
    end
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_in    <= '0;
      en_out   <= '0;
      en_ig    <= '0;
      en_og    <= '0;
      en_err   <= '0;
      thr_in   <= '0;
      thr_out  <= '0;
      mask_in  <= '0;
      mask_out <= '0;
    end else if (wr_vld) begin
      en_in    <= en_in_d;
      en_out   <= en_out_d;
      en_ig    <= en_ig_d;
      en_og    <= en_og_d;
      en_err   <= en_err_d;
      thr_in   <= thr_in_d;
      thr_out  <= thr_out_d;
      mask_in  <= mask_in_d;
      mask_out <= mask_out_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (addr)
      A_IN_STS:  rd_data = REG_W'(en_in);
      A_OUT_STS: rd_data = REG_W'(en_out);
      A_IG_STS:  rd_data = REG_W'(en_ig);
      A_OG_STS:  rd_data = REG_W'(en_og);
      A_ER_STS:  rd_data = REG_W'(en_err);
      A_ER_ACK:  rd_data = REG_W'(err_flags);
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == TIN_BASE + ADDR_W'(c))  rd_data = REG_W'(thr_in[c]);
      if (addr == TOUT_BASE + ADDR_W'(c)) rd_data = REG_W'(thr_out[c]);
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr == GIN_BASE + ADDR_W'(g))  rd_data = REG_W'(mask_in[g]);
      if (addr == GOUT_BASE + ADDR_W'(g)) rd_data = REG_W'(mask_out[g]);
    end
  end
endmodule

// File: rtl/fia_cond.sv
`timescale 1ns/1ps
module fia_cond #(
  parameter int NUM_CH  = 8,
  parameter int LVL_W   = 6,
  parameter int NUM_GRP = 4
) (
  input  logic [NUM_CH-1:0][LVL_W-1:0]   lvl_in,
  input  logic [NUM_CH-1:0][LVL_W-1:0]   lvl_out,
  input  logic [NUM_CH-1:0][LVL_W-1:0]   thr_in,
  input  logic [NUM_CH-1:0][LVL_W-1:0]   thr_out,
  input  logic [NUM_GRP-1:0][NUM_CH-1:0] mask_in,
  input  logic [NUM_GRP-1:0][NUM_CH-1:0] mask_out,
  output logic [NUM_CH-1:0]              below,
  output logic [NUM_CH-1:0]              above,
  output logic [NUM_GRP-1:0]             ig_hit,
  output logic [NUM_GRP-1:0]             og_hit
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign below[c] = lvl_in[c]  < thr_in[c];
    assign above[c] = lvl_out[c] > thr_out[c];
  end

  // a group qualifies when its mask is non-empty and no member fails
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign ig_hit[g] = (|mask_in[g])  && (&(below | ~mask_in[g]));
    assign og_hit[g] = (|mask_out[g]) && (&(above | ~mask_out[g]));
  end
endmodule

// File: rtl/fifo_irq_agg.sv
`timescale 1ns/1ps
module fifo_irq_agg
  import fia_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int LVL_W   = 6,
  parameter int NUM_GRP = 4,
  parameter int REG_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*LVL_W-1:0]   in_level,
  input  logic [NUM_CH*LVL_W-1:0]   out_level,
  input  logic [NUM_CH-1:0]         ovf_pulse,
  input  logic [NUM_CH-1:0]         unf_pulse,
  input  logic                      reg_valid,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      irq_infifo,
  output logic                      irq_outfifo,
  output logic                      irq_ingrp,
  output logic                      irq_outgrp,
  output logic                      irq_error
);
  logic [NUM_CH-1:0]               en_in, en_out, en_err, err_ack;
  logic [NUM_GRP-1:0]              en_ig, en_og;
  logic [NUM_CH-1:0][LVL_W-1:0]    thr_in, thr_out, lvl_in, lvl_out;
  logic [NUM_GRP-1:0][NUM_CH-1:0]  mask_in, mask_out;
  logic [NUM_CH-1:0]               below, above;
  logic [NUM_GRP-1:0]              ig_hit, og_hit;
  logic [NUM_CH-1:0]               err_flag_q, err_flag_d;
  logic                            irq_in_d, irq_out_d, irq_ig_d, irq_og_d, irq_er_d;

  assign lvl_in  = in_level;
  assign lvl_out = out_level;

  fia_regs #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .NUM_GRP(NUM_GRP), .REG_W(REG_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld   (reg_valid),
    .addr     (reg_addr),
    .wr_data  (reg_wdata),
    .err_flags(err_flag_q),
    .rd_data  (reg_rdata),
    .en_in    (en_in),
    .en_out   (en_out),
    .en_ig    (en_ig),
    .en_og    (en_og),
    .en_err   (en_err),
    .err_ack  (err_ack),
    .thr_in   (thr_in),
    .thr_out  (thr_out),
    .mask_in  (mask_in),
    .mask_out (mask_out)
  );

  fia_cond #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .NUM_GRP(NUM_GRP)
  ) u_cond (
    .lvl_in  (lvl_in),
    .lvl_out (lvl_out),
    .thr_in  (thr_in),
    .thr_out (thr_out),
    .mask_in (mask_in),
    .mask_out(mask_out),
    .below   (below),
    .above   (above),
    .ig_hit  (ig_hit),
    .og_hit  (og_hit)
  );

  // next state: a new event outranks an acknowledge on the same channel
  always_comb begin
    err_flag_d = (err_flag_q & ~err_ack) | ovf_pulse | unf_pulse;
    irq_in_d   = |(en_in  & below);
    irq_out_d  = |(en_out & above);
    irq_ig_d   = |(en_ig  & ig_hit);
    irq_og_d   = |(en_og  & og_hit);
    irq_er_d   = |(en_err & err_flag_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag_q  <= '0;
      irq_infifo  <= 1'b0;
      irq_outfifo <= 1'b0;
      irq_ingrp   <= 1'b0;
      irq_outgrp  <= 1'b0;
      irq_error   <= 1'b0;
    end else begin
      err_flag_q  <= err_flag_d;
      irq_infifo  <= irq_in_d;
      irq_outfifo <= irq_out_d;
      irq_ingrp   <= irq_ig_d;
      irq_outgrp  <= irq_og_d;
      irq_error   <= irq_er_d;
    end
  end
endmodule

// File: rtl/fia_chk.sv
`timescale 1ns/1ps
module fia_chk
  import fia_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_GRP = 4,
  parameter int REG_W   = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            reg_valid,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic [REG_W-1:0]                reg_wdata,
  input logic [NUM_CH-1:0]               en_in,
  input logic [NUM_CH-1:0]               en_out,
  input logic [NUM_GRP-1:0]              en_ig,
  input logic [NUM_CH-1:0]               below,
  input logic [NUM_CH-1:0]               above,
  input logic [NUM_GRP-1:0][NUM_CH-1:0]  mask_in,
  input logic [NUM_CH-1:0]               ovf_pulse,
  input logic [NUM_CH-1:0]               unf_pulse,
  input logic [NUM_CH-1:0]               err_flag_q,
  input logic                            irq_infifo,
  input logic                            irq_outfifo,
  input logic                            irq_ingrp
);
  logic [NUM_GRP-1:0] grp_nz;
  logic [NUM_CH-1:0]  evt;
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_nz
    assign grp_nz[g] = |mask_in[g];
  end
  assign evt = ovf_pulse | unf_pulse;

  assert_infifo_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_infifo |-> $past(|(en_in & below)));

  assert_outfifo_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_outfifo |-> $past(|(en_out & above)));

  assert_empty_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ingrp |-> $past(|(en_ig & grp_nz)));

  assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_addr == A_IN_SET) |=>
      ((en_in & $past(reg_wdata[NUM_CH-1:0])) == $past(reg_wdata[NUM_CH-1:0])));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_addr == A_IN_CLR) |=>
      ((en_in & $past(reg_wdata[NUM_CH-1:0])) == '0));

  assert_err_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((err_flag_q & $past(evt)) == $past(evt)));
endmodule

bind fifo_irq_agg fia_chk #(
  .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .REG_W(REG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_valid  (reg_valid),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .en_in      (en_in),
  .en_out     (en_out),
  .en_ig      (en_ig),
  .below      (below),
  .above      (above),
  .mask_in    (mask_in),
  .ovf_pulse  (ovf_pulse),
  .unf_pulse  (unf_pulse),
  .err_flag_q (err_flag_q),
  .irq_infifo (irq_infifo),
  .irq_outfifo(irq_outfifo),
  .irq_ingrp  (irq_ingrp)
);

// File: tb/fifo_irq_agg_bench.sv
`timescale 1ns/1ps
module fifo_irq_agg_bench;
  localparam int NC = 8;
  localparam int LW = 6;
  localparam int NG = 4;

  localparam logic [5:0] IN_STS = 6'h00, IN_SET = 6'h01, IN_CLR = 6'h02;
  localparam logic [5:0] OUT_STS = 6'h03, OUT_SET = 6'h04;
  localparam logic [5:0] IG_SET = 6'h07, OG_SET = 6'h0A;
  localparam logic [5:0] ER_SET = 6'h0D, ER_ACK = 6'h0F;

  logic clk, rst_n;
  logic [NC*LW-1:0] in_level, out_level;
  logic [NC-1:0] ovf_pulse, unf_pulse;
  logic reg_valid;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq_infifo, irq_outfifo, irq_ingrp, irq_outgrp, irq_error;

  fifo_irq_agg u_fifo_irq_agg (
    .clk(clk), .rst_n(rst_n), .in_level(in_level), .out_level(out_level),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .reg_valid(reg_valid),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_infifo(irq_infifo), .irq_outfifo(irq_outfifo), .irq_ingrp(irq_ingrp),
    .irq_outgrp(irq_outgrp), .irq_error(irq_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model
  logic [LW-1:0] lin [NC];
  logic [LW-1:0] lout[NC];
  logic [LW-1:0] m_tin [NC];
  logic [LW-1:0] m_tout[NC];
  logic [NC-1:0] m_gin [NG];
  logic [NC-1:0] m_gout[NG];
  logic [NC-1:0] m_en_in, m_en_out, m_en_err, m_flag;
  logic [NG-1:0] m_en_ig, m_en_og;
  int n_chk, n_fail;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      in_level[i*LW +: LW]  = lin[i];
      out_level[i*LW +: LW] = lout[i];
    end
  end

  function automatic logic f_in();
    logic r = 1'b0;
    for (int c = 0; c < NC; c++) if (m_en_in[c] && lin[c] < m_tin[c]) r = 1'b1;
    return r;
  endfunction
  function automatic logic f_out();
    logic r = 1'b0;
    for (int c = 0; c < NC; c++) if (m_en_out[c] && lout[c] > m_tout[c]) r = 1'b1;
    return r;
  endfunction
  function automatic logic f_ig();
    logic r = 1'b0;
    for (int g = 0; g < NG; g++) begin
      logic ok = (m_gin[g] != '0) && m_en_ig[g];
      for (int c = 0; c < NC; c++) if (m_gin[g][c] && !(lin[c] < m_tin[c])) ok = 1'b0;
      if (ok) r = 1'b1;
    end
    return r;
  endfunction
  function automatic logic f_og();
    logic r = 1'b0;
    for (int g = 0; g < NG; g++) begin
      logic ok = (m_gout[g] != '0) && m_en_og[g];
      for (int c = 0; c < NC; c++) if (m_gout[g][c] && !(lout[c] > m_tout[c])) ok = 1'b0;
      if (ok) r = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // one write cycle; model tracks the effect
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0;
    case (a)
      6'h01: m_en_in  = m_en_in | d;
      6'h02: m_en_in  = m_en_in & ~d;
      6'h04: m_en_out = m_en_out | d;
      6'h05: m_en_out = m_en_out & ~d;
      6'h07: m_en_ig  = m_en_ig | d[NG-1:0];
      6'h08: m_en_ig  = m_en_ig & ~d[NG-1:0];
      6'h0A: m_en_og  = m_en_og | d[NG-1:0];
      6'h0B: m_en_og  = m_en_og & ~d[NG-1:0];
      6'h0D: m_en_err = m_en_err | d;
      6'h0E: m_en_err = m_en_err & ~d;
      6'h0F: m_flag   = m_flag & ~d;
      default: begin
        if (a >= 6'h10 && a < 6'h18) m_tin[a-6'h10]  = d[LW-1:0];
        else if (a >= 6'h18 && a < 6'h20) m_tout[a-6'h18] = d[LW-1:0];
        else if (a >= 6'h20 && a < 6'h24) m_gin[a-6'h20]  = d;
        else if (a >= 6'h24 && a < 6'h28) m_gout[a-6'h24] = d;
      end
    endcase
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // one cycle with current levels and given event pulses, then compare all lines
  task automatic step(input logic [NC-1:0] o, input logic [NC-1:0] u);
    ovf_pulse = o; unf_pulse = u;
    @(negedge clk);
    ovf_pulse = '0; unf_pulse = '0;
    m_flag = m_flag | o | u;
    check("R1 irq_infifo",  irq_infifo,  f_in());
    check("R2 irq_outfifo", irq_outfifo, f_out());
    check("R3 irq_ingrp",   irq_ingrp,   f_ig());
    check("R3 irq_outgrp",  irq_outgrp,  f_og());
    check("R7 irq_error",   irq_error,   |(m_flag & m_en_err));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250311));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_valid = 1'b0; reg_addr = '0; reg_wdata = '0;
    ovf_pulse = '0; unf_pulse = '0;
    for (int i = 0; i < NC; i++) begin lin[i] = 6'd63; lout[i] = 6'd0; m_tin[i] = '0; m_tout[i] = '0; end
    for (int g = 0; g < NG; g++) begin m_gin[g] = '0; m_gout[g] = '0; end
    m_en_in = '0; m_en_out = '0; m_en_err = '0; m_flag = '0; m_en_ig = '0; m_en_og = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irq lines", {irq_infifo, irq_outfifo, irq_ingrp, irq_outgrp, irq_error}, 5'b0);
    rd("R9 in enables", IN_STS, 8'h00);
    rd("R9 threshold", 6'h13, 8'h00);
    rd("R9 flags", ER_ACK, 8'h00);

    // R5 set/clear semantics
    wr(IN_SET, 8'hA5); rd("R5 set", IN_STS, 8'hA5);
    wr(IN_SET, 8'h0F); rd("R5 set or", IN_STS, 8'hAF);
    wr(IN_CLR, 8'h21); rd("R5 clear", IN_STS, 8'h8E);
    wr(IN_CLR, 8'h00); rd("R5 zero clear ignored", IN_STS, 8'h8E);
    wr(IN_SET, 8'h00); rd("R5 zero set ignored", IN_STS, 8'h8E);
    rd("R5 set addr reads zero", IN_SET, 8'h00);

    // R6 table readback
    wr(6'h13, 8'hCA); rd("R6 in threshold", 6'h13, 8'h0A);
    wr(6'h1D, 8'd20); rd("R6 out threshold", 6'h1D, 8'd20);
    wr(6'h21, 8'h3C); rd("R6 in mask", 6'h21, 8'h3C);
    wr(6'h26, 8'h81); rd("R6 out mask", 6'h26, 8'h81);

    // R1 boundary on channel 3 (enabled), threshold 10
    lin[3] = 6'd9;  step('0, '0); check("R1 below fires", irq_infifo, 1'b1);
    lin[3] = 6'd10; step('0, '0); check("R1 equal quiet", irq_infifo, 1'b0);
    wr(IN_CLR, 8'h08); lin[3] = 6'd2; step('0, '0);
    check("R1 disabled quiet", irq_infifo, 1'b0);

    // R2 boundary on channel 5, threshold 20
    wr(OUT_SET, 8'h20);
    lout[5] = 6'd20; step('0, '0); check("R2 equal quiet", irq_outfifo, 1'b0);
    lout[5] = 6'd21; step('0, '0); check("R2 above fires", irq_outfifo, 1'b1);

    // R3 group 1 over channels 2..5, one member short then all
    for (int c = 2; c < 6; c++) wr(6'(6'h10 + c), 8'd30);
    wr(IG_SET, 8'h02);
    for (int c = 2; c < 6; c++) lin[c] = 6'd5;
    lin[4] = 6'd30; step('0, '0); check("R3 one member short", irq_ingrp, 1'b0);
    lin[4] = 6'd29; step('0, '0); check("R3 all members below", irq_ingrp, 1'b1);

    // R4 empty mask never fires
    wr(6'h21, 8'h00); wr(IG_SET, 8'h0F);
    for (int c = 0; c < NC; c++) begin lin[c] = 6'd0; wr(6'(6'h10 + c), 8'd40); end
    for (int g = 0; g < NG; g++) wr(6'(6'h20 + g), 8'h00);
    step('0, '0); check("R4 empty mask quiet", irq_ingrp, 1'b0);

    // R7 capture without enable, then enable
    step(8'h04, '0); check("R7 masked quiet", irq_error, 1'b0);
    rd("R7 flag captured", ER_ACK, 8'h04);
    wr(ER_SET, 8'h04); step('0, '0); check("R7 enabled fires", irq_error, 1'b1);
    step('0, 8'h40); rd("R7 underflow flag", ER_ACK, 8'h44);

    // R8 acknowledge
    wr(ER_ACK, 8'h01); rd("R8 zero bits keep", ER_ACK, 8'h44);
    wr(ER_ACK, 8'h04); rd("R8 ack clears", ER_ACK, 8'h40);
    step('0, '0); check("R8 line drops", irq_error, 1'b0);
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = ER_ACK; reg_wdata = 8'h40; unf_pulse = 8'h40;
    @(negedge clk);
    reg_valid = 1'b0; unf_pulse = '0;
    rd("R8 event beats ack", ER_ACK, 8'h40);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k = $urandom % 10;
      logic [NC-1:0] po, pu;
      if (k < 5) begin
        logic [5:0] a;
        case (k)
          0: a = 6'(6'h10 + $urandom % 8);
          1: a = 6'(6'h18 + $urandom % 8);
          2: a = 6'(6'h20 + $urandom % 8);
          3: a = 6'(6'h01 + $urandom % 14);
          default: a = 6'(6'h01 + $urandom % 15);
        endcase
        wr(a, 8'($urandom));
      end
      for (int c = 0; c < NC; c++) begin
        lin[c]  = 6'($urandom);
        lout[c] = 6'($urandom);
      end
      po = (($urandom % 4) == 0) ? NC'($urandom) : '0;
      pu = (($urandom % 4) == 0) ? NC'($urandom) : '0;
      step(po, pu);
    end
    rd("R7 flags after random", ER_ACK, m_flag);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule